// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block takes a byte stream of incoming frames and writes each one into a circular region of packet RAM. The region is cut into 256-byte pages. The host programs a first page, a limit page, a fence (boundary) page and the page where the next frame begins. Every frame starts four bytes into the current page, which leaves a header slot in front of the frame data. When a frame ends intact, the block goes back and fills that slot. It writes a status byte, the page where the following frame will begin, and the stored length. It then moves the current page forward and raises a receive interrupt.

Frames with a failed check word are dropped: the current page does not move, so the next frame writes over them. If a write would cross into the fence page, the block stops storing the frame at that point. It leaves the current page alone, raises an overflow interrupt and bumps a missed-frame tally. The RAM port carries byte writes only, with the full address formed as {page, offset}. The host reads frames back through a separate path and frees space by moving the fence page.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset the first page and fence page are 0x46, the current page is 0x46 and the limit page is 0x80. No RAM write occurs, both interrupt bits are 0, the missed tally is 0 and the receive status is 0.
- R2: A one-cycle `cfg_we` loads `cfg_wdata` into the register picked by `cfg_sel`: 0 first page, 1 limit page, 2 fence page, 3 current page. The new value shows on the matching output after that clock edge.
- R3: Byte k of a frame (k from 0, first byte marked by `rx_sof`) is written one cycle after it is accepted. The address is the one after byte k-1, and byte 0 goes to offset 4 of the current page.
- R4: When a write address passes offset 0xFF of a page, the next address is offset 0 of the following page. The following page is the first page when the page after it equals the limit page.
- R5: After the last byte of a frame with `rx_crc_ok` high, four writes follow to offsets 0..3 of the frame's first page. They carry, in order, 0x01, the next page, the length low byte and the length high byte. The length is the frame byte count plus 4.
- R6: The next page is the page after the one holding the last byte, with the R4 wrap applied. Once the header is written, the current page takes that value and `int_rx` becomes 1.
- R7: A frame ending with `rx_crc_ok` low gets no header write. The current page and `int_rx` stay unchanged, and the receive status becomes 0x02 (bit 1).
- R8: A byte whose address is offset 0 of the fence page is not written, and the rest of that frame is dropped. The current page stays unchanged, `int_ovw` becomes 1, `miss_cnt` goes up by one and the receive status becomes 0x10 (bit 4).
- R9: `int_clr` bit 0 clears `int_rx` and bit 1 clears `int_ovw`. Each bit leaves the other interrupt untouched.
- R10: Valid bytes that arrive with no frame open (no prior `rx_sof`) cause no RAM write and leave the current page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 first, 1 limit, 2 fence, 3 current) |
| cfg_wdata | input | 8 | Register write data |
| int_clr | input | 2 | Write-one-to-clear for int_rx (bit 0) and int_ovw (bit 1) |
| rx_valid | input | 1 | Byte present on rx_data |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Frame byte |
| rx_crc_ok | input | 1 | Frame check passed, sampled with rx_eof |
| ram_we | output | 1 | Packet RAM write enable |
| ram_addr | output | 16 | Packet RAM byte address {page, offset} |
| ram_wdata | output | 8 | Packet RAM write data |
| start_pg | output | 8 | First ring page |
| stop_pg | output | 8 | Limit page (one past the last ring page) |
| bnry_pg | output | 8 | Fence page |
| curr_pg | output | 8 | Page where the next frame begins |
| int_rx | output | 1 | Good frame stored |
| int_ovw | output | 1 | Ring overflow |
| miss_cnt | output | 8 | Frames lost to overflow |
| rx_stat | output | 8 | Status of the last frame (bit 0 intact, bit 1 check error, bit 4 missed) |

## Verification
The assertions assume the stream leaves at least four idle cycles after each frame's last byte, so the header writes finish before the next frame begins. They also assume the host does not touch the page registers while a frame is being stored, and keeps the current page inside the range from first to limit page. The stimulus respects all three. It spaces frames six cycles apart, programs the registers only between frames, and keeps a four-page ring in which every current page it writes is a ring page. Within those limits the scoreboard predicts every RAM write, covering wrap, page-end fill and fence crossing. It builds those predictions from its own ring model.

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr #(
  parameter int PG_W      = 8,
  parameter int MISS_W    = 8,
  parameter logic [PG_W-1:0] DEF_START = 8'h46,
  parameter logic [PG_W-1:0] DEF_STOP  = 8'h80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [7:0]           cfg_wdata,
  input  logic [1:0]           int_clr,
  input  logic                 rx_valid,
  input  logic                 rx_sof,
  input  logic                 rx_eof,
  input  logic [7:0]           rx_data,
  input  logic                 rx_crc_ok,
  output logic                 ram_we,
  output logic [PG_W+7:0]      ram_addr,
  output logic [7:0]           ram_wdata,
  output logic [PG_W-1:0]      start_pg,
  output logic [PG_W-1:0]      stop_pg,
  output logic [PG_W-1:0]      bnry_pg,
  output logic [PG_W-1:0]      curr_pg,
  output logic                 int_rx,
  output logic                 int_ovw,
  output logic [MISS_W-1:0]    miss_cnt,
  output logic [7:0]           rx_stat
);
  localparam int AW = PG_W + 8;

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_DROP, S_HDR} st_t;
  st_t st;

  logic [AW-1:0]   wp;
  logic [15:0]     len;
  logic [1:0]      hidx;
  logic [PG_W-1:0] nxt_pg;

  function automatic logic [PG_W-1:0] pg_inc(input logic [PG_W-1:0] p,
                                             input logic [PG_W-1:0] lo,
                                             input logic [PG_W-1:0] hi);
    pg_inc = (p + 1'b1 == hi) ? lo : p + 1'b1;
  endfunction

  logic            byte_go, hit;
  logic [AW-1:0]   addr_now, addr_nxt;
  logic [15:0]     len_now;
  logic [PG_W-1:0] pg_now, pg_after;

  assign byte_go  = rx_valid && (rx_sof ? (st != S_HDR) : (st == S_RECV));
  assign addr_now = rx_sof ? {curr_pg, 8'h04} : wp;
  assign len_now  = rx_sof ? 16'd4 : len;
  assign pg_now   = addr_now[AW-1:8];
  assign pg_after = pg_inc(pg_now, start_pg, stop_pg);
  assign hit      = (addr_now[7:0] == 8'h00) && (pg_now == bnry_pg);
  assign addr_nxt = (addr_now[7:0] == 8'hff) ? {pg_after, 8'h00} : addr_now + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      wp        <= '0;
      len       <= '0;
      hidx      <= '0;
      nxt_pg    <= '0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      start_pg  <= DEF_START;
      stop_pg   <= DEF_STOP;
      bnry_pg   <= DEF_START;
      curr_pg   <= DEF_START;
      int_rx    <= 1'b0;
      int_ovw   <= 1'b0;
      miss_cnt  <= '0;
      rx_stat   <= '0;
    end else begin
      ram_we <= 1'b0;
      if (int_clr[0]) int_rx  <= 1'b0;
      if (int_clr[1]) int_ovw <= 1'b0;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: start_pg <= cfg_wdata;
          2'd1: stop_pg  <= cfg_wdata;
          2'd2: bnry_pg  <= cfg_wdata;
          default: curr_pg <= cfg_wdata;
        endcase
      end

      if (st == S_HDR) begin
        ram_we   <= 1'b1;
        ram_addr <= {curr_pg, 6'd0, hidx};
        case (hidx)
          2'd0: ram_wdata <= 8'h01;
          2'd1: ram_wdata <= nxt_pg;
          2'd2: ram_wdata <= len[7:0];
          default: ram_wdata <= len[15:8];
        endcase
        hidx <= hidx + 2'd1;
        if (hidx == 2'd3) begin
          curr_pg <= nxt_pg;
          int_rx  <= 1'b1;
          st      <= S_IDLE;
        end
      end else if (byte_go && !hit) begin
        ram_we    <= 1'b1;
        ram_addr  <= addr_now;
        ram_wdata <= rx_data;
        wp        <= addr_nxt;
        len       <= len_now + 16'd1;
        if (rx_eof) begin
          if (rx_crc_ok) begin
            st      <= S_HDR;
            hidx    <= 2'd0;
            nxt_pg  <= pg_after;
            rx_stat <= 8'h01;
          end else begin
            st      <= S_IDLE;
            rx_stat <= 8'h02;
          end
        end else begin
          st <= S_RECV;
        end
      end else if (byte_go && hit) begin
        st       <= rx_eof ? S_IDLE : S_DROP;
        int_ovw  <= 1'b1;
        miss_cnt <= miss_cnt + 1'b1;
        rx_stat  <= 8'h10;
      end else if (st == S_DROP && rx_valid && rx_eof) begin
        st <= S_IDLE;
      end
    end
  end
endmodule

// File: rtl/rx_ring_chk.sv
module rx_ring_chk #(
  parameter int PG_W   = 8,
  parameter int MISS_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              rx_valid,
  input logic              rx_sof,
  input logic              rx_eof,
  input logic              rx_crc_ok,
  input logic              ram_we,
  input logic [PG_W+7:0]   ram_addr,
  input logic [PG_W-1:0]   start_pg,
  input logic [PG_W-1:0]   stop_pg,
  input logic [PG_W-1:0]   curr_pg,
  input logic              int_rx,
  input logic              int_ovw,
  input logic [MISS_W-1:0] miss_cnt
);
  p_first_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_sof) |=> (ram_we && ram_addr == {$past(curr_pg), 8'h04}));

  p_in_ring_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr[PG_W+7:8] >= start_pg && ram_addr[PG_W+7:8] < stop_pg));

  p_curr_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (curr_pg != $past(curr_pg) && !$past(cfg_we)) |-> int_rx);

  p_bad_no_hdr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_eof && !rx_crc_ok) |-> ##2 !ram_we);

  p_ovw_tally_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_ovw) |-> (miss_cnt == $past(miss_cnt) + 1'b1));
endmodule

bind rx_ring_mgr rx_ring_chk #(.PG_W(PG_W), .MISS_W(MISS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .rx_valid(rx_valid),
  .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok),
  .ram_we(ram_we), .ram_addr(ram_addr), .start_pg(start_pg),
  .stop_pg(stop_pg), .curr_pg(curr_pg), .int_rx(int_rx),
  .int_ovw(int_ovw), .miss_cnt(miss_cnt));

// File: tb/sim_rx_ring_mgr.sv
module sim_rx_ring_mgr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic [1:0] int_clr = '0;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_crc_ok = 1'b0;
  logic [7:0] rx_data = '0;
  logic ram_we;
  logic [15:0] ram_addr;
  logic [7:0] ram_wdata, start_pg, stop_pg, bnry_pg, curr_pg, miss_cnt, rx_stat;
  logic int_rx, int_ovw;

  always #4 clk = ~clk;

  rx_ring_mgr u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .int_clr(int_clr), .rx_valid(rx_valid),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data), .rx_crc_ok(rx_crc_ok),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .start_pg(start_pg), .stop_pg(stop_pg), .bnry_pg(bnry_pg), .curr_pg(curr_pg),
    .int_rx(int_rx), .int_ovw(int_ovw), .miss_cnt(miss_cnt), .rx_stat(rx_stat));

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [23:0] exp_q[$];
  logic [7:0] m_start, m_stop, m_bnry, m_curr, m_miss, m_stat;
  logic m_rx, m_ovw;

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && ram_we) begin
      if (exp_q.size() == 0) chk("R10 unexpected write", {ram_addr}, 16'hxxxx);
      else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk("R3/R5 write addr", ram_addr, e[23:8]);
        chk("R3/R5 write data", {8'h00, ram_wdata}, {8'h00, e[7:0]});
      end
    end
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  function automatic logic [7:0] inc(input logic [7:0] p);
    return (p + 8'd1 == m_stop) ? m_start : p + 8'd1;
  endfunction

  task automatic cfg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
    case (s)
      2'd0: m_start = d;
      2'd1: m_stop = d;
      2'd2: m_bnry = d;
      default: m_curr = d;
    endcase
  endtask

  task automatic clr(input logic [1:0] c);
    @(negedge clk); int_clr = c;
    @(negedge clk); int_clr = 2'b00;
    if (c[0]) m_rx = 1'b0;
    if (c[1]) m_ovw = 1'b0;
  endtask

  task automatic send(input int n, input bit ok, input logic [7:0] seed);
    logic [15:0] a, last;
    bit ovf;
    ovf = 0;
    a = {m_curr, 8'h04};
    last = a;
    for (int i = 0; i < n; i++) begin
      if (i > 0 && a[7:0] == 8'h00 && a[15:8] == m_bnry) begin
        ovf = 1;
        break;
      end
      exp_q.push_back({a, seed + 8'(i)});
      last = a;
      a = (a[7:0] == 8'hff) ? {inc(a[15:8]), 8'h00} : a + 16'd1;
    end
    if (ovf) begin
      m_ovw = 1; m_miss++; m_stat = 8'h10;
    end else if (ok) begin
      logic [7:0] nx;
      logic [15:0] ln;
      nx = inc(last[15:8]);
      ln = 16'(n + 4);
      exp_q.push_back({m_curr, 8'h00, 8'h01});
      exp_q.push_back({m_curr, 8'h01, nx});
      exp_q.push_back({m_curr, 8'h02, ln[7:0]});
      exp_q.push_back({m_curr, 8'h03, ln[15:8]});
      m_curr = nx; m_rx = 1; m_stat = 8'h01;
    end else begin
      m_stat = 8'h02;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == n - 1);
      rx_data = seed + 8'(i); rx_crc_ok = ok;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_crc_ok = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic state(input string r);
    chk({r, " curr_pg"}, {8'h00, curr_pg}, {8'h00, m_curr});
    chk({r, " rx_stat"}, {8'h00, rx_stat}, {8'h00, m_stat});
    chk({r, " int_rx"}, {15'd0, int_rx}, {15'd0, m_rx});
    chk({r, " int_ovw"}, {15'd0, int_ovw}, {15'd0, m_ovw});
    chk({r, " miss_cnt"}, {8'h00, miss_cnt}, {8'h00, m_miss});
  endtask

  initial begin
    m_start = 8'h46; m_stop = 8'h80; m_bnry = 8'h46; m_curr = 8'h46;
    m_miss = 0; m_stat = 0; m_rx = 0; m_ovw = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 start_pg", {8'h00, start_pg}, 16'h0046);
    chk("R1 stop_pg", {8'h00, stop_pg}, 16'h0080);
    chk("R1 bnry_pg", {8'h00, bnry_pg}, 16'h0046);
    chk("R1 ram_we", {15'd0, ram_we}, 16'h0000);
    state("R1");
    // R2 register writes: ring of pages 0x10..0x13
    cfg(2'd0, 8'h10); cfg(2'd1, 8'h14); cfg(2'd2, 8'h10); cfg(2'd3, 8'h10);
    chk("R2 start_pg", {8'h00, start_pg}, 16'h0010);
    chk("R2 stop_pg", {8'h00, stop_pg}, 16'h0014);
    chk("R2 bnry_pg", {8'h00, bnry_pg}, 16'h0010);
    chk("R2 curr_pg", {8'h00, curr_pg}, 16'h0010);
    // R10 stray bytes with no frame open
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'hee; rx_eof = (i == 4);
    end
    @(negedge clk); rx_valid = 1'b0; rx_eof = 1'b0;
    repeat (4) @(negedge clk);
    state("R10");
    // R3 R5 R6 one-page frame
    send(60, 1'b1, 8'h20);
    state("R6 good frame");
    // R9 clear receive bit only
    clr(2'b01);
    state("R9 clear rx");
    // R7 bad frame
    send(10, 1'b0, 8'h40);
    state("R7 bad frame");
    // R3 frame spanning pages
    send(300, 1'b1, 8'h50);
    state("R3 multi page");
    // R4 wrap from limit to first page
    cfg(2'd2, 8'h12);
    send(300, 1'b1, 8'h60);
    state("R4 wrap");
    // R8 overflow into fence page
    send(300, 1'b1, 8'h70);
    state("R8 overflow");
    // R9 clear overflow bit only
    clr(2'b10);
    state("R9 clear ovw");
    // R5 single-byte frame
    send(1, 1'b1, 8'h99);
    state("R5 one byte");
    // R6 frame ending on the last byte of a page, then one crossing with wrap
    send(252, 1'b1, 8'h11);
    state("R6 page end");
    send(253, 1'b1, 8'h33);
    state("R6 wrap next");
    chk("R3 all writes seen", 16'(exp_q.size()), 16'd0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule